// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the message-signalled interrupt capability structure that sits in a device's configuration space. Configuration writes carry a byte offset relative to the capability base, a length of one to four bytes and a 32-bit data word. The block applies each byte to the register it lands on. It keeps read-only fields fixed and stores the message address, the message data, the per-vector mask and the pending bits. A registered 32-bit read port returns the assembled dword at any capability offset.

The device raises interrupt events on a vector input. While MSI is enabled, an event on a masked vector is recorded as pending. An event on an unmasked vector becomes a delivery request straight away. Clearing a mask bit while MSI is enabled and that vector is pending also produces a delivery request. Delivery requests leave one per cycle, lowest vector first, and each delivery clears the vector's pending bit. Building the message and running the bus transaction are left to the logic downstream.

Parameters fix the vector count, 32-bit or 64-bit address layout, whether per-vector masking exists, and the next-capability pointer.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset, dword 0 reads {control, next pointer, 0x05}. In control, bit 0 (enable) is 0 and bits 6:4 (enabled count) are 0. Bits 3:1 hold the smallest n in 0..5 with 2^n >= NUM_VEC. Bit 7 equals ADDR64 and bit 8 equals MASK_EN. Mask and pending are zero.
- R2: Writes to bytes 0, 1 and 3 are ignored. In byte 2, only bit 0 and bits 6:4 take the written value, and bits 1, 2, 3 and 7 keep their values.
- R3: A write of length N (1..4) places data byte i (bits 8i+7:8i) at offset base+i, for each i < N.
- R4: With ADDR64=1, the address low word is at 0x04, the high word at 0x08, data at 0x0C, mask at 0x10 and pending at 0x14. With ADDR64=0, the address is at 0x04, data at 0x08, mask at 0x0C and pending at 0x10.
- R5: The data register is 16 bits wide. The upper two bytes of its dword read as zero and ignore writes.
- R6: The pending register ignores all configuration writes.
- R7: An event on a vector below NUM_VEC whose mask bit is set, while enabled, sets that pending bit and produces no delivery.
- R8: An event on an unmasked vector below NUM_VEC, while enabled, gives dlv_valid with dlv_vec equal to that vector on the second rising edge after the event, and leaves pending unchanged.
- R9: While enabled, a write that takes mask bit b of mask byte k from 1 to 0, with pending bit 8k+b set, delivers vector 8k+b. Every delivery clears that vector's pending bit.
- R10: When several deliveries are outstanding, they leave one per cycle in ascending vector order.
- R11: While not enabled, events are ignored, and clearing mask bits neither delivers nor clears pending bits.
- R12: cfg_rd_data shows the dword at cfg_rd_off one cycle later. Offset bits 1:0 are ignored, and offsets at or beyond the capability size read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wr_off | input | 6 | Byte offset of the first written byte |
| cfg_wr_len | input | 3 | Bytes in the write, 1 to 4 |
| cfg_wr_data | input | 32 | Write data, lowest byte first |
| cfg_rd_off | input | 6 | Read offset |
| cfg_rd_data | output | 32 | Registered read dword |
| irq_valid | input | 1 | Interrupt event strobe |
| irq_vec | input | 5 | Vector of the event |
| dlv_valid | output | 1 | Delivery request |
| dlv_vec | output | 5 | Vector to deliver |

## Verification
The bench builds two instances. The main one uses the 64-bit layout, 20 vectors and a non-zero next pointer. With 20 vectors the capability field reaches 5, and mask bytes 0 to 2 all cover live vectors, so unmasking across byte boundaries and multi-byte mask writes are both exercised. The second instance uses the 32-bit layout with 3 vectors. It checks the alternate offset map, a capability field of 2, and the shorter capability size that reads as zero.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam logic [7:0] CAP_ID_MSI = 8'h05;
  localparam int         LANES      = 4;
  localparam int         VEC_SLOTS  = 32;
  localparam int         VW         = 5;

  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_CTRL,
    FLD_ADDR_LO,
    FLD_ADDR_HI,
    FLD_DATA,
    FLD_MASK
  } fld_e;

  typedef struct packed {
    logic       act;
    fld_e       fld;
    logic [1:0] bidx;
  } lane_t;

  // Smallest n (0..5) with 2**n >= count
  function automatic logic [2:0] mmc_of(input int count);
    logic [2:0] r;
    logic       found;
    r = 3'd5;
    found = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (!found && ((1 << i) >= count)) begin
        r = 3'(i);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  // Map a capability byte offset to the writable field it lands on
  function automatic lane_t classify(input logic [6:0] off, input bit a64, input bit men);
    lane_t r;
    r.act  = 1'b0;
    r.bidx = off[1:0];
    r.fld  = FLD_NONE;
    if (off == 7'd2) r.fld = FLD_CTRL;
    else if (off[6:2] == 5'd1) r.fld = FLD_ADDR_LO;
    else if (a64) begin
      if (off[6:2] == 5'd2) r.fld = FLD_ADDR_HI;
      else if (off[6:1] == 6'd6) r.fld = FLD_DATA;
      else if (off[6:2] == 5'd4 && men) r.fld = FLD_MASK;
    end else begin
      if (off[6:1] == 6'd4) r.fld = FLD_DATA;
      else if (off[6:2] == 5'd3 && men) r.fld = FLD_MASK;
    end
    return r;
  endfunction

endpackage

// File: rtl/msi_lane_decode.sv
module msi_lane_decode
  import msi_cap_pkg::*;
#(
  parameter int LANE    = 0,
  parameter bit ADDR64  = 1'b1,
  parameter bit MASK_EN = 1'b1
) (
  input  logic       wr,
  input  logic [5:0] base_off,
  input  logic [2:0] len,
  output lane_t      lane
);
  logic [6:0] off;
  assign off = {1'b0, base_off} + 7'(LANE);

  always_comb begin
    lane     = classify(off, ADDR64, MASK_EN);
    lane.act = wr && (3'(LANE) < len);
  end
endmodule

// File: rtl/msi_vec_pick.sv
module msi_vec_pick #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic [W-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  // Lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int         NUM_VEC  = 8,
  parameter bit         ADDR64   = 1'b1,
  parameter bit         MASK_EN  = 1'b1,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr,
  input  logic [5:0]  cfg_wr_off,
  input  logic [2:0]  cfg_wr_len,
  input  logic [31:0] cfg_wr_data,
  input  logic [5:0]  cfg_rd_off,
  output logic [31:0] cfg_rd_data,
  input  logic        irq_valid,
  input  logic [4:0]  irq_vec,
  output logic        dlv_valid,
  output logic [4:0]  dlv_vec
);
  localparam logic [2:0] MMC       = mmc_of(NUM_VEC);
  localparam int         CAP_BYTES = MASK_EN ? (ADDR64 ? 24 : 20) : (ADDR64 ? 16 : 12);

  generate
    if (NUM_VEC < 1 || NUM_VEC > VEC_SLOTS) begin : g_bad_cfg
      $error("msi_cap_regs: NUM_VEC must be 1..32");
    end
  endgenerate

  logic                 en_q;
  logic [2:0]           mme_q;
  logic [31:0]          addr_lo_q, addr_hi_q;
  logic [15:0]          data_q;
  logic [VEC_SLOTS-1:0] mask_q, mask_nx, pend_q, fire_q;
  logic [VEC_SLOTS-1:0] unmask_fire, irq_oh, irq_masked, irq_direct;
  logic [VEC_SLOTS-1:0] pick_gnt;
  logic [VW-1:0]        pick_idx;
  logic                 pick_any, vec_ok;
  lane_t                lanes [LANES];

  // One decoder per byte lane of the write word
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      msi_lane_decode #(.LANE(g), .ADDR64(ADDR64), .MASK_EN(MASK_EN)) u_dec (
        .wr       (cfg_wr),
        .base_off (cfg_wr_off),
        .len      (cfg_wr_len),
        .lane     (lanes[g])
      );
    end
  endgenerate

  // Next mask value, needed before the edge to spot 1->0 transitions
  always_comb begin
    mask_nx = mask_q;
    for (int l = 0; l < LANES; l++) begin
      if (lanes[l].act && lanes[l].fld == FLD_MASK)
        mask_nx[8*lanes[l].bidx +: 8] = cfg_wr_data[8*l +: 8];
    end
  end

  assign unmask_fire = en_q ? (mask_q & ~mask_nx & pend_q) : '0;
  assign vec_ok      = irq_valid && en_q && (int'(irq_vec) < NUM_VEC);
  assign irq_oh      = VEC_SLOTS'(1) << irq_vec;
  assign irq_masked  = (vec_ok && (mask_q & irq_oh) != '0) ? irq_oh : '0;
  assign irq_direct  = (vec_ok && (mask_q & irq_oh) == '0) ? irq_oh : '0;

  msi_vec_pick #(.W(VEC_SLOTS), .IW(VW)) u_pick (
    .req (fire_q),
    .gnt (pick_gnt),
    .idx (pick_idx),
    .any (pick_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      mme_q     <= '0;
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      data_q    <= '0;
      mask_q    <= '0;
      pend_q    <= '0;
      fire_q    <= '0;
      dlv_valid <= 1'b0;
      dlv_vec   <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (lanes[l].act) begin
          case (lanes[l].fld)
            FLD_CTRL: begin
              en_q  <= cfg_wr_data[8*l];
              mme_q <= cfg_wr_data[8*l+4 +: 3];
            end
            FLD_ADDR_LO: addr_lo_q[8*lanes[l].bidx +: 8] <= cfg_wr_data[8*l +: 8];
            FLD_ADDR_HI: addr_hi_q[8*lanes[l].bidx +: 8] <= cfg_wr_data[8*l +: 8];
            FLD_DATA:    data_q[8*lanes[l].bidx[0] +: 8] <= cfg_wr_data[8*l +: 8];
            default: ;
          endcase
        end
      end
      mask_q    <= mask_nx;
      pend_q    <= (pend_q & ~pick_gnt) | irq_masked;
      fire_q    <= (fire_q & ~pick_gnt) | unmask_fire | irq_direct;
      dlv_valid <= pick_any;
      dlv_vec   <= pick_idx;
    end
  end

  // Registered read port
  logic [15:0] ctrl_w;
  logic [31:0] mask_rd, pend_rd, data_rd;
  assign ctrl_w  = {7'd0, MASK_EN, ADDR64, mme_q, MMC, en_q};
  assign mask_rd = MASK_EN ? mask_q : '0;
  assign pend_rd = MASK_EN ? pend_q : '0;
  assign data_rd = {16'd0, data_q};

  always_ff @(posedge clk) begin
    if (rst) cfg_rd_data <= '0;
    else if (int'({cfg_rd_off[5:2], 2'b00}) >= CAP_BYTES) cfg_rd_data <= '0;
    else begin
      case (cfg_rd_off[5:2])
        4'd0:    cfg_rd_data <= {ctrl_w, NEXT_PTR, CAP_ID_MSI};
        4'd1:    cfg_rd_data <= addr_lo_q;
        4'd2:    cfg_rd_data <= ADDR64 ? addr_hi_q : data_rd;
        4'd3:    cfg_rd_data <= ADDR64 ? data_rd : mask_rd;
        4'd4:    cfg_rd_data <= ADDR64 ? mask_rd : pend_rd;
        4'd5:    cfg_rd_data <= ADDR64 ? pend_rd : '0;
        default: cfg_rd_data <= '0;
      endcase
    end
  end

  // Assertions
  p_pend_on_masked_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && en_q && int'(irq_vec) < NUM_VEC && mask_q[irq_vec]) |=> pend_q[$past(irq_vec)]);

  p_dlv_in_range_r8: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> (int'(dlv_vec) < NUM_VEC));

  p_unmask_delivers_r9: assert property (@(posedge clk) disable iff (rst)
    (|unmask_fire) |=> ##1 dlv_valid);

  p_pend_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !($past(irq_valid) && $past(irq_vec) == dlv_vec)) |-> !pend_q[dlv_vec]);

  p_gnt_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick_gnt));

  p_no_event_off_r11: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !mask_q[irq_vec] && irq_valid) |=> !fire_q[$past(irq_vec)] || $past(fire_q[irq_vec]));
endmodule

// File: tb/msi_cap_regs_tb_top.sv
module msi_cap_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_wr_off = '0;
  logic [2:0]  cfg_wr_len = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [5:0]  cfg_rd_off = '0;
  logic        irq_valid = 1'b0;
  logic [4:0]  irq_vec = '0;
  logic [31:0] rd1, rd2;
  logic        dlv1, dlv2;
  logic [4:0]  dvec1, dvec2;
  int          checks = 0;
  int          errors = 0;
  int          exp_q[$];

  always #2.5 clk = ~clk;

  msi_cap_regs #(.NUM_VEC(20), .ADDR64(1'b1), .MASK_EN(1'b1), .NEXT_PTR(8'h70)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr && !sel), .cfg_wr_off(cfg_wr_off),
    .cfg_wr_len(cfg_wr_len), .cfg_wr_data(cfg_wr_data), .cfg_rd_off(cfg_rd_off),
    .cfg_rd_data(rd1), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .dlv_valid(dlv1), .dlv_vec(dvec1));

  msi_cap_regs #(.NUM_VEC(3), .ADDR64(1'b0), .MASK_EN(1'b1), .NEXT_PTR(8'h00)) dut2_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr && sel), .cfg_wr_off(cfg_wr_off),
    .cfg_wr_len(cfg_wr_len), .cfg_wr_data(cfg_wr_data), .cfg_rd_off(cfg_rd_off),
    .cfg_rd_data(rd2), .irq_valid(1'b0), .irq_vec(5'd0),
    .dlv_valid(dlv2), .dlv_vec(dvec2));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] off, input logic [2:0] len, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wr_off = off; cfg_wr_len = len; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] off, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_rd_off = off;
    @(negedge clk);
    if (sel) chk(rd2 === exp, tag, rd2, exp);
    else     chk(rd1 === exp, tag, rd1, exp);
  endtask

  task automatic irq(input logic [4:0] v);
    @(negedge clk);
    irq_valid = 1'b1; irq_vec = v;
    @(negedge clk);
    irq_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // Scoreboard monitor: pops expected vectors as deliveries appear
  always @(negedge clk) begin
    if (!rst && dlv1) begin
      if (exp_q.size() == 0) chk(1'b0, "R8/R9 unexpected delivery", 32'(dvec1), 32'hFFFF_FFFF);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(dvec1 == 5'(e), "R10 delivery order", 32'(dvec1), 32'(e));
      end
    end
    if (!rst && dlv2) chk(1'b0, "R11 second instance delivery", 32'(dvec2), 32'h0);
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Exact two-edge latency for a direct event (R8)
  task automatic latency_chk();
    @(negedge clk);
    irq_valid = 1'b1; irq_vec = 5'd6;
    exp_q.push_back(6);
    @(negedge clk);
    irq_valid = 1'b0;
    chk(dlv1 === 1'b0, "R8 latency one edge", 32'(dlv1), 32'h0);
    @(negedge clk);
    chk(dlv1 === 1'b1 && dvec1 == 5'd6, "R8 latency two edges", {dlv1, 26'd0, dvec1}, {1'b1, 26'd0, 5'd6});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    rd_chk(6'h00, 32'h018A_7005, "R1 header");
    rd_chk(6'h10, 32'h0, "R1 mask zero");
    rd_chk(6'h14, 32'h0, "R1 pending zero");
    // R2 read-only fields
    wr(6'h00, 3'd4, 32'hFFFF_FFFF);
    rd_chk(6'h00, 32'h01FB_7005, "R2 only enable and count writable");
    wr(6'h02, 3'd1, 32'h0000_0000);
    wr(6'h03, 3'd1, 32'h0000_00FF);
    rd_chk(6'h00, 32'h018A_7005, "R2 high byte ignored");
    wr(6'h02, 3'd1, 32'h0000_0021);
    rd_chk(6'h00, 32'h01AB_7005, "R2 enable set");
    // R4 / R3 address layout and byte placement
    wr(6'h04, 3'd4, 32'h1234_5678);
    wr(6'h08, 3'd4, 32'h9ABC_DEF0);
    rd_chk(6'h04, 32'h1234_5678, "R4 address low");
    rd_chk(6'h08, 32'h9ABC_DEF0, "R4 address high");
    wr(6'h05, 3'd2, 32'h0000_BBAA);
    rd_chk(6'h04, 32'h12BB_AA78, "R3 unaligned two-byte write");
    rd_chk(6'h06, 32'h12BB_AA78, "R12 low offset bits ignored");
    // R5 data width
    wr(6'h0C, 3'd4, 32'hFFFF_BEEF);
    rd_chk(6'h0C, 32'h0000_BEEF, "R5 data upper bytes zero");
    // R4 mask, R6 pending read-only
    wr(6'h10, 3'd4, 32'h000F_0F0F);
    rd_chk(6'h10, 32'h000F_0F0F, "R4 mask");
    wr(6'h14, 3'd4, 32'hFFFF_FFFF);
    rd_chk(6'h14, 32'h0, "R6 pending ignores writes");
    // R7 masked event becomes pending
    irq(5'd2); settle();
    rd_chk(6'h14, 32'h0000_0004, "R7 pending set");
    // R8 unmasked event delivered, pending unchanged
    exp_q.push_back(5);
    irq(5'd5); settle();
    rd_chk(6'h14, 32'h0000_0004, "R8 pending unchanged");
    latency_chk(); settle();
    // R9 / R10 unmask several pending vectors
    irq(5'd0); irq(5'd3); settle();
    rd_chk(6'h14, 32'h0000_000D, "R7 several pending");
    exp_q.push_back(0); exp_q.push_back(2); exp_q.push_back(3);
    wr(6'h10, 3'd1, 32'h0000_0000); settle();
    rd_chk(6'h14, 32'h0, "R9 pending cleared on delivery");
    rd_chk(6'h10, 32'h000F_0F00, "R9 mask updated");
    // R11 disabled: unmask does nothing, events ignored
    irq(5'd16); settle();
    rd_chk(6'h14, 32'h0001_0000, "R7 vector 16 pending");
    wr(6'h02, 3'd1, 32'h0000_0020);
    wr(6'h12, 3'd1, 32'h0000_000E); settle();
    rd_chk(6'h14, 32'h0001_0000, "R11 pending kept while disabled");
    irq(5'd9); irq(5'd4); settle();
    rd_chk(6'h14, 32'h0001_0000, "R11 events ignored while disabled");
    // R9 re-enable, remask and unmask vector 16 = byte 2 bit 0
    wr(6'h02, 3'd1, 32'h0000_0021);
    wr(6'h12, 3'd1, 32'h0000_000F);
    exp_q.push_back(16);
    wr(6'h12, 3'd1, 32'h0000_000E); settle();
    rd_chk(6'h14, 32'h0, "R9 vector 16 delivered");
    // R10 two-byte unmask across bytes, ascending order
    irq(5'd17); irq(5'd9); irq(5'd11); settle();
    rd_chk(6'h14, 32'h0002_0A00, "R7 pending 9 11 17");
    exp_q.push_back(9); exp_q.push_back(11); exp_q.push_back(17);
    wr(6'h11, 3'd2, 32'h0000_0000); settle();
    rd_chk(6'h14, 32'h0, "R10 all delivered");
    // R12 beyond capability size
    rd_chk(6'h18, 32'h0, "R12 beyond size");
    rd_chk(6'h3C, 32'h0, "R12 far offset");
    // Second instance: 32-bit layout, 3 vectors
    sel = 1'b1;
    rd_chk(6'h00, 32'h0104_0005, "R1 32-bit header");
    wr(6'h08, 3'd4, 32'hAAAA_5555);
    rd_chk(6'h08, 32'h0000_5555, "R4 32-bit data offset");
    wr(6'h0C, 3'd4, 32'h0000_0007);
    rd_chk(6'h0C, 32'h0000_0007, "R4 32-bit mask offset");
    rd_chk(6'h10, 32'h0, "R4 32-bit pending offset");
    rd_chk(6'h14, 32'h0, "R12 32-bit beyond size");
    sel = 1'b0;
    settle();
    chk(exp_q.size() == 0, "R10 all expected deliveries seen", 32'(exp_q.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule